// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Thresholds

This block is a first-in-first-out buffer whose write side and read side run on two unrelated clocks. Either clock may be slow, fast or stopped. The two clock domains exchange their pointers as Gray code through synchronizer chains. The write domain raises the full flag, the half-full flag and the near-full warning. The read domain raises the empty flag and the near-empty warning.

Two offset registers set the near-empty and near-full warning points. Master reset fills both registers from one of eight built-in pairs, chosen by three pins. After reset, software on the write-clock side can overwrite the offsets one bit at a time through a serial input. The block is meant for buffering between two subsystems whose clocks share no relationship, where the consumer wants early notice before the buffer drains and the producer wants early notice before it fills.

Top module: `fifo_pf`

## Requirements
- R1: Words leave in the order they were accepted. A read is accepted when `rdEn` is high and `emptyFlag` is low at a rising `rdClk` edge. On that edge, `rdData` takes the oldest stored word.
- R2: A write presented while `fullFlag` is high is dropped, and the stored contents do not change. A read presented while `emptyFlag` is high is dropped, and `rdData` keeps its previous value.
- R3: Occupancy is the number of accepted writes minus the number of accepted reads. `emptyFlag` is high when the read side sees zero occupancy. `fullFlag` is high when the write side sees occupancy equal to the depth. A flag driven by the same side's own action updates on that side's edge. A flag driven by the far side's action updates within three edges of its own clock.
- R4: `halfFlag` is high exactly when the occupancy seen by the write side is more than half the depth.
- R5: `almostEmpty` is high exactly when the occupancy seen by the read side is at most the near-empty offset.
- R6: `almostFull` is high exactly when the free space seen by the write side (depth minus occupancy) is at most the near-full offset.
- R7: While the write domain is in reset, each write-clock edge loads both offsets from the 3-bit selector {`serLoad`, `presetSel[1]`, `presetSel[0]`}. The loaded value is min(2^(s+3) − 1, depth − 1), where s is the selector. The pins must be held until the third write-clock edge after `mrstN` rises.
- R8: Outside reset, each write-clock edge with both `serEn` and `serLoad` high stores one `serIn` bit into the offsets. The first log2(depth) bits fill the near-empty offset, least significant bit first. The next log2(depth) bits fill the near-full offset in the same way. After that, the sequence starts again at the near-empty offset. An edge with only one of `serEn` or `serLoad` high changes nothing.
- R9: When `mrstN` goes low, both pointers go to the first location at once, with no clock edge needed. The flags then read empty=1, almostEmpty=1, full=0, half=0 and almostFull=0. Each domain leaves reset on its second clock edge after `mrstN` rises. Writes presented during reset are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| rdClk | input | 1 | Read-side clock |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Last word read out |
| mrstN | input | 1 | Master reset, active low, asynchronous assertion |
| presetSel | input | 2 | Lower two bits of the reset-time offset selector |
| serLoad | input | 1 | Top selector bit during reset; serial-load qualifier after reset |
| serEn | input | 1 | Serial-load enable |
| serIn | input | 1 | Serial offset bit |
| emptyFlag | output | 1 | Nothing to read |
| fullFlag | output | 1 | No room to write |
| halfFlag | output | 1 | More than half the depth in use |
| almostEmpty | output | 1 | Occupancy at or below near-empty offset |
| almostFull | output | 1 | Free space at or below near-full offset |

## Verification
The two ports can act on the same instant. A read can free a slot while the write side, still seeing the stale synchronized read pointer, keeps `fullFlag` high and has to drop a write. The mirror case is a write landing while the reader still sees empty. Both cases are provoked by long streams with random enables on both sides, with the read clock slower, faster and nearly equal to the write clock, so that the buffer sits against each boundary for many cycles. The bench decides whether each request was accepted from the flag value it sees at that edge. It then judges every word read against a queue model built only from the accepted requests.

// File: rtl/fifo_pf_pkg.sv
`timescale 1ns/1ps
package fifo_pf_pkg;

  // Strobes handed from the control to the storage array.
  typedef struct packed {
    logic push;   // write-clock domain: store wrData at wrAddr
    logic pop;    // read-clock domain: load rdData from rdAddr
  } memStrobe_t;

  localparam int SEL_W = 3;

  // Reset-time offset table: 2^(sel+3)-1, limited to depth-1.
  function automatic int unsigned presetOffset(input logic [SEL_W-1:0] sel,
                                               input int unsigned depth);
    int unsigned raw;
    raw = (32'd1 << (32'(sel) + 32'd3)) - 32'd1;
    return (raw > depth - 32'd1) ? depth - 32'd1 : raw;
  endfunction

endpackage

// File: rtl/fifo_pf_rstsync.sv
`timescale 1ns/1ps
module fifo_pf_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  output logic rst
);
  logic [STAGES-1:0] chain;

  // Immediate entry into reset, release after STAGES clock edges.
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= (chain << 1) | STAGES'(1);
  end

  assign rst = ~chain[STAGES-1];
endmodule

// File: rtl/fifo_pf_offsets.sv
`timescale 1ns/1ps
module fifo_pf_offsets
  import fifo_pf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             wrClk,
  input  logic             wrRst,
  input  logic [SEL_W-1:0] selPins,
  input  logic             serEn,
  input  logic             serLoad,
  input  logic             serIn,
  output logic [AW-1:0]    aeOff,
  output logic [AW-1:0]    afOff
);
  localparam int DEPTH = 1 << AW;
  localparam int BITS  = 2 * AW;
  localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;

  logic [CNT_W-1:0] bitPos;
  logic [AW-1:0]    presetVal;
  logic             shiftNow;

  assign presetVal = AW'(presetOffset(selPins, DEPTH));
  assign shiftNow  = serEn && serLoad;

  // Pins are sampled on every edge while reset is held; serial bits land
  // at bitPos, near-empty offset first, then near-full, then wrap.
  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      aeOff  <= presetVal;
      afOff  <= presetVal;
      bitPos <= '0;
    end else if (shiftNow) begin
      for (int i = 0; i < AW; i++) begin
        if (bitPos == CNT_W'(i))      aeOff[i] <= serIn;
        if (bitPos == CNT_W'(i + AW)) afOff[i] <= serIn;
      end
      bitPos <= (bitPos == CNT_W'(BITS - 1)) ? '0 : bitPos + 1'b1;
    end
  end

  // R8: without both qualifiers the offsets do not move
  p_serial_qualified_r8: assert property (@(posedge wrClk) disable iff (wrRst)
    !shiftNow |=> ($stable(aeOff) && $stable(afOff)));

  // R8: one serial edge touches at most one offset bit
  p_one_bit_per_edge_r8: assert property (@(posedge wrClk) disable iff (wrRst)
    shiftNow |=> ($countones(aeOff ^ $past(aeOff)) + $countones(afOff ^ $past(afOff)) <= 1));

  // R8: position counter stays inside the 2*AW bit sequence
  p_pos_range_r8: assert property (@(posedge wrClk) disable iff (wrRst)
    bitPos < CNT_W'(BITS));
endmodule

// File: rtl/fifo_pf_store.sv
`timescale 1ns/1ps
module fifo_pf_store
  import fifo_pf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rdRst,
  input  memStrobe_t    strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst)           rdData <= '0;
    else if (strobe.pop) rdData <= mem[rdAddr];
  end

  // R2: the output register only moves on an accepted read
  p_hold_without_pop_r2: assert property (@(posedge rdClk) disable iff (rdRst)
    !strobe.pop |=> $stable(rdData));
endmodule

// File: rtl/fifo_pf_ctrl.sv
`timescale 1ns/1ps
module fifo_pf_ctrl
  import fifo_pf_pkg::*;
#(
  parameter int AW   = 6,
  parameter int SYNC = 2
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          wrRst,
  input  logic          rdRst,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] aeOff,
  input  logic [AW-1:0] afOff,
  output memStrobe_t    strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyFlag,
  output logic          fullFlag,
  output logic          halfFlag,
  output logic          almostEmpty,
  output logic          almostFull
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0]           wrBin, wrGray, rdBinSeen, occW, freeW;
  logic [SYNC-1:0][PW-1:0] rdGrayPipe;
  logic [PW-1:0]           rdGray;
  logic                    doPush;

  assign doPush = wrEn && !fullFlag && !wrRst;

  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (doPush) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst) rdGrayPipe <= '0;
    else begin
      rdGrayPipe[0] <= rdGray;
      for (int i = 1; i < SYNC; i++) rdGrayPipe[i] <= rdGrayPipe[i-1];
    end
  end

  assign rdBinSeen  = toBin(rdGrayPipe[SYNC-1]);
  assign occW       = wrBin - rdBinSeen;
  assign freeW      = FULL_CNT - occW;
  assign fullFlag   = (occW == FULL_CNT);
  assign halfFlag   = (occW > HALF_CNT);
  assign almostFull = (freeW <= {1'b0, afOff});

  // ---------------- read domain ----------------
  logic [PW-1:0]           rdBin, wrBinSeen, occR;
  logic [SYNC-1:0][PW-1:0] wrGrayPipe;
  logic                    doPop;

  assign doPop = rdEn && !emptyFlag && !rdRst;

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (doPop) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= toGray(rdBin + 1'b1);
    end
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) wrGrayPipe <= '0;
    else begin
      wrGrayPipe[0] <= wrGray;
      for (int i = 1; i < SYNC; i++) wrGrayPipe[i] <= wrGrayPipe[i-1];
    end
  end

  assign wrBinSeen   = toBin(wrGrayPipe[SYNC-1]);
  assign occR        = wrBinSeen - rdBin;
  assign emptyFlag   = (occR == '0);
  assign almostEmpty = (occR <= {1'b0, aeOff});

  // ---------------- strobes to storage ----------------
  assign strobe.push = doPush;
  assign strobe.pop  = doPop;
  assign wrAddr      = wrBin[AW-1:0];
  assign rdAddr      = rdBin[AW-1:0];

  // R2: a full buffer keeps its write pointer
  p_no_overflow_r2: assert property (@(posedge wrClk) disable iff (wrRst)
    fullFlag |=> (wrBin == $past(wrBin)));

  // R2: an empty buffer keeps its read pointer
  p_no_underflow_r2: assert property (@(posedge rdClk) disable iff (rdRst)
    emptyFlag |=> (rdBin == $past(rdBin)));

  // R3: the crossing code changes by at most one bit per edge
  p_gray_wr_step_r3: assert property (@(posedge wrClk) disable iff (wrRst)
    ##1 ($countones(wrGray ^ $past(wrGray)) <= 1));
  p_gray_rd_step_r3: assert property (@(posedge rdClk) disable iff (rdRst)
    ##1 ($countones(rdGray ^ $past(rdGray)) <= 1));

  // R3: neither side ever sees more than the depth
  p_occ_bound_w_r3: assert property (@(posedge wrClk) disable iff (wrRst) occW <= FULL_CNT);
  p_occ_bound_r_r3: assert property (@(posedge rdClk) disable iff (rdRst) occR <= FULL_CNT);

  // R4, R6: a full buffer is past half and inside the near-full window
  p_full_implies_half_r4: assert property (@(posedge wrClk) disable iff (wrRst)
    fullFlag |-> (halfFlag && almostFull));

  // R5: an empty buffer is inside the near-empty window
  p_empty_implies_ae_r5: assert property (@(posedge rdClk) disable iff (rdRst)
    emptyFlag |-> almostEmpty);
endmodule

// File: rtl/fifo_pf.sv
`timescale 1ns/1ps
module fifo_pf
  import fifo_pf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH_LOG2  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              mrstN,
  input  logic [1:0]        presetSel,
  input  logic              serLoad,
  input  logic              serEn,
  input  logic              serIn,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              halfFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int AW = DEPTH_LOG2;

  logic          wrRst, rdRst;
  logic [AW-1:0] aeOff, afOff, wrAddr, rdAddr;
  memStrobe_t    strobe;

  fifo_pf_rstsync #(.STAGES(SYNC_STAGES)) uWrRst (.clk(wrClk), .arstN(mrstN), .rst(wrRst));
  fifo_pf_rstsync #(.STAGES(SYNC_STAGES)) uRdRst (.clk(rdClk), .arstN(mrstN), .rst(rdRst));

  fifo_pf_offsets #(.AW(AW)) uOffsets (
    .wrClk(wrClk), .wrRst(wrRst), .selPins({serLoad, presetSel}),
    .serEn(serEn), .serLoad(serLoad), .serIn(serIn),
    .aeOff(aeOff), .afOff(afOff)
  );

  fifo_pf_ctrl #(.AW(AW), .SYNC(SYNC_STAGES)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .wrRst(wrRst), .rdRst(rdRst),
    .wrEn(wrEn), .rdEn(rdEn), .aeOff(aeOff), .afOff(afOff),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag), .halfFlag(halfFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  fifo_pf_store #(.DW(DATA_W), .AW(AW)) uStore (
    .wrClk(wrClk), .rdClk(rdClk), .rdRst(rdRst), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/tb_fifo_pf.sv
`timescale 1ns/1ps
module tb_fifo_pf;
  localparam int DW    = 8;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          wrClk = 0, rdClk = 0;
  logic          wrEn = 0, rdEn = 0, mrstN = 0;
  logic [DW-1:0] wrData = '0;
  logic [1:0]    presetSel = '0;
  logic          serLoad = 0, serEn = 0, serIn = 0;
  logic [DW-1:0] rdData;
  logic          emptyFlag, fullFlag, halfFlag, almostEmpty, almostFull;

  realtime rdHalf = 3.1;
  always #2 wrClk = ~wrClk;             // 250 MHz write clock
  always #(rdHalf) rdClk = ~rdClk;

  fifo_pf #(.DATA_W(DW), .DEPTH_LOG2(AW), .SYNC_STAGES(2)) dut (
    .wrClk(wrClk), .wrEn(wrEn), .wrData(wrData), .rdClk(rdClk), .rdEn(rdEn),
    .rdData(rdData), .mrstN(mrstN), .presetSel(presetSel), .serLoad(serLoad),
    .serEn(serEn), .serIn(serIn), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .halfFlag(halfFlag), .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  int nChecks = 0, nFail = 0;
  logic [DW-1:0] model[$];
  logic [DW-1:0] lastRead = '0;
  logic [DW-1:0] seq = 8'h11;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge wrClk);
    repeat (5) @(posedge rdClk);
    #0.3;
  endtask

  task automatic doReset(input logic [2:0] sel);
    mrstN = 0; wrEn = 0; rdEn = 0; serEn = 0;
    {serLoad, presetSel} = sel;
    repeat (5) @(posedge wrClk);
    repeat (2) @(posedge rdClk);
    @(negedge wrClk) mrstN = 1;
    repeat (4) @(posedge wrClk);
    repeat (4) @(posedge rdClk);
    @(negedge wrClk) begin serLoad = 0; presetSel = '0; end
    model.delete();
    lastRead = '0;
  endtask

  task automatic checkFlags(input int ae, input int af, input string cfg);
    int occ = model.size();
    check("R3 empty",         32'(emptyFlag),   32'(occ == 0));
    check("R3 full",          32'(fullFlag),    32'(occ == DEPTH));
    check("R4 half",          32'(halfFlag),    32'(occ > DEPTH / 2));
    check({"R5 almostEmpty ", cfg}, 32'(almostEmpty), 32'(occ <= ae));
    check({"R6 almostFull ", cfg},  32'(almostFull),  32'((DEPTH - occ) <= af));
  endtask

  task automatic pushWord(input logic [DW-1:0] v);
    logic acc;
    @(negedge wrClk) begin wrData = v; wrEn = 1; acc = !fullFlag; end
    @(negedge wrClk) wrEn = 0;
    if (acc) model.push_back(v);
  endtask

  task automatic popWord();
    logic acc;
    logic [DW-1:0] e;
    @(negedge rdClk) begin rdEn = 1; acc = !emptyFlag; end
    @(negedge rdClk) rdEn = 0;
    if (acc) begin
      e = model.pop_front();
      check("R1 order", 32'(rdData), 32'(e));
      lastRead = e;
    end else begin
      check("R2 read while empty", 32'(rdData), 32'(lastRead));
    end
  endtask

  task automatic sweep(input int ae, input int af, input string cfg);
    settle();
    checkFlags(ae, af, cfg);
    for (int i = 0; i < DEPTH; i++) begin
      pushWord(seq); seq = seq + 8'd7;
      settle();
      checkFlags(ae, af, cfg);
    end
    for (int i = 0; i < 3; i++) begin
      pushWord(seq); seq = seq + 8'd7;
    end
    settle();
    check("R2 write while full size", 32'(model.size()), 32'(DEPTH));
    check("R2 full holds", 32'(fullFlag), 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      popWord();
      settle();
      checkFlags(ae, af, cfg);
    end
    popWord();
    popWord();
    settle();
    check("R2 empty holds", 32'(emptyFlag), 32'd1);
  endtask

  task automatic serialBits(input logic [31:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk) begin serEn = 1; serLoad = 1; serIn = bits[i]; end
    end
    @(negedge wrClk) begin serEn = 0; serLoad = 0; serIn = 0; end
  endtask

  task automatic stream(input realtime half, input int nWords);
    rdHalf = half;
    fork
      begin : writer
        int sent = 0;
        while (sent < nWords) begin
          @(negedge wrClk);
          wrEn = ($urandom % 10) < 7;
          wrData = seq;
          if (wrEn && !fullFlag) begin
            model.push_back(seq); seq = seq + 8'd3; sent++;
          end
        end
        @(negedge wrClk) wrEn = 0;
      end
      begin : reader
        int got = 0;
        logic pend = 0;
        logic [DW-1:0] e = '0;
        while (got < nWords || pend) begin
          @(negedge rdClk);
          if (pend) begin
            check("R1 stream order", 32'(rdData), 32'(e));
            pend = 0;
          end
          if (got < nWords) begin
            rdEn = ($urandom % 10) < 6;
            if (rdEn && !emptyFlag) begin
              e = model.pop_front(); pend = 1; got++;
            end
          end else rdEn = 0;
        end
        rdEn = 0;
      end
    join
    settle();
    check("R3 empty after stream", 32'(emptyFlag), 32'd1);
  endtask

  initial begin
    #400000;
    nFail++; nChecks++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R9: state after a reset with selector 000 (offsets 7/7, R7)
    doReset(3'b000);
    check("R9 empty", 32'(emptyFlag), 32'd1);
    check("R9 almostEmpty", 32'(almostEmpty), 32'd1);
    check("R9 full", 32'(fullFlag), 32'd0);
    check("R9 half", 32'(halfFlag), 32'd0);
    check("R9 almostFull", 32'(almostFull), 32'd0);
    check("R9 rdData", 32'(rdData), 32'd0);
    sweep(7, 7, "R7 sel000");

    doReset(3'b010);          // 31
    sweep(31, 31, "R7 sel010");
    doReset(3'b101);          // 255 limited to 63
    sweep(63, 63, "R7 sel101");

    // R8: serial load ae=5, af=20, then unqualified edges, then wrap onto ae
    doReset(3'b000);
    serialBits({20'd0, 6'd20, 6'd5}, 12);
    for (int i = 0; i < 6; i++) @(negedge wrClk) begin serEn = 1; serLoad = 0; serIn = 1; end
    for (int i = 0; i < 6; i++) @(negedge wrClk) begin serEn = 0; serLoad = 1; serIn = 1; end
    @(negedge wrClk) begin serEn = 0; serLoad = 0; serIn = 0; end
    sweep(5, 20, "R8 serial");
    serialBits({26'd0, 6'd9}, 6);
    sweep(9, 20, "R8 wrap");

    // R9: asynchronous reset with data inside, writes during reset dropped
    for (int i = 0; i < 40; i++) begin pushWord(seq); seq = seq + 8'd1; end
    settle();
    check("R4 half before reset", 32'(halfFlag), 32'd1);
    #0.7 mrstN = 0;
    #1;
    check("R9 async empty", 32'(emptyFlag), 32'd1);
    check("R9 async half", 32'(halfFlag), 32'd0);
    check("R9 async almostFull", 32'(almostFull), 32'd0);
    model.delete();
    for (int i = 0; i < 3; i++) @(negedge wrClk) begin wrEn = 1; wrData = 8'hEE; end
    @(negedge wrClk) begin wrEn = 0; mrstN = 1; end
    settle();
    check("R9 writes in reset dropped", 32'(emptyFlag), 32'd1);
    lastRead = '0;
    popWord();

    // R1, R2, R3: concurrent streams with unrelated clocks
    doReset(3'b000);
    stream(3.3, 300);
    stream(1.4, 300);
    stream(2.07, 300);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule